// File: doc/BRIEF.md
# Parallel Camera Sync Capture

This block takes pixel samples from a camera sensor that uses separate vertical and horizontal sync wires. The sensor's pixel clock is not used as a clock. It is passed through a short synchronizer into the system clock domain with the data and both syncs, and its selected edge becomes a one-cycle sample strobe. On each strobe the block tracks frame and line boundaries. It gates the samples that fall inside an active line of an acquired frame and packs them into 32-bit words.

Control comes from quasi-static inputs:

- enable and a frame-trigger choice, which decides whether a disable takes effect at once or at the end of the frame;
- a start mode: begin on an active vertical sync level, or only on its inactive-to-active transition;
- independent sync and clock polarities;
- a 3-bit sample-width code;
- a lane swap;
- a state-machine reset that only works while the block is disabled.

Four one-cycle event pulses mark frame start, frame end, line start and line end.

Top module: `cam_sync_capture`

## Requirements
- R1: With `pclk_pol`=0 data is sampled on the rising edge of `cam_pclk`; with `pclk_pol`=1 it is sampled on the falling edge.
- R2: `vs_pol` and `hs_pol` act independently; 0 means the sync is active high, 1 means active low.
- R3: With `start_edge`=0 acquisition begins on any sample where vertical sync is active, even partway through a frame. With `start_edge`=1 it begins only on a sample where vertical sync changes from inactive to active.
- R4: `mode`=000 takes 8-bit samples, packed four per word, with the first sample in bits [7:0]. `mode`=001 takes 10-bit samples and `mode`=010 takes 12-bit samples; each is zero-extended to a 16-bit lane and packed two per word, with the first sample in bits [15:0].
- R5: Any other `mode` code produces no output words, but the four events are still reported.
- R6: With `swap`=1 the lane order inside each word is reversed, so the first sample of the word goes in the most significant lane.
- R7: A partly filled word left when a line ends is emitted with its unfilled lanes zero.
- R8: Events are single-cycle pulses in this order:
  - frame start on the sample where acquisition begins;
  - line start on the sample where horizontal sync becomes active;
  - line end on the sample where it becomes inactive;
  - frame end on the sample where vertical sync becomes inactive.
- R9: Clearing `en` while `frame_trig`=0 stops capture at once. No further words or events are produced, and a partly filled word is discarded.
- R10: Clearing `en` while `frame_trig`=1 lets the current frame finish with all its words, line events and frame end. No new frame is then started.
- R11: A `fsm_rst` pulse while `en`=0 returns capture to idle at once, ending a deferred-stop frame with no further output. While `en`=1 the pulse has no effect.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_pclk | input | 1 | Sensor pixel clock, sampled as data |
| cam_vs | input | 1 | Sensor vertical sync |
| cam_hs | input | 1 | Sensor horizontal sync |
| cam_data | input | PIX_W | Sensor pixel data |
| en | input | 1 | Capture enable |
| frame_trig | input | 1 | 1: a disable waits for the end of the frame |
| start_edge | input | 1 | 1: start only on the vertical sync transition to active |
| vs_pol | input | 1 | Vertical sync polarity (1 = active low) |
| hs_pol | input | 1 | Horizontal sync polarity (1 = active low) |
| pclk_pol | input | 1 | Sample edge (0 rising, 1 falling) |
| mode | input | 3 | Sample width code |
| swap | input | 1 | Reverse lane order in words |
| fsm_rst | input | 1 | State-machine reset, honoured while disabled |
| word | output | WORD_W | Packed output word |
| word_vld | output | 1 | One-cycle strobe for `word` |
| frame_start | output | 1 | Frame start event pulse |
| frame_end | output | 1 | Frame end event pulse |
| line_start | output | 1 | Line start event pulse |
| line_end | output | 1 | Line end event pulse |

## Verification
The bench sweeps every combination of the width codes, swap, clock polarity and both sync polarities over short frames whose line lengths leave a partial word at each line end. A packer that fills lanes in the wrong order or skips the zero-fill would emit wrong words. A design that samples on the wrong edge or ignores a polarity would start late, split lines, or lose the frame altogether.

Further frames enable capture partway through a frame in both start modes. The level-start design must pick up the frame; an edge-start design that counted the stale sync level would wrongly capture it. Other frames disable or reset the state machine in the middle of a line under each trigger setting. A design that still flushed the partial word, missed the deferred frame end, or obeyed the reset while enabled shows extra or missing words and events.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

   typedef enum logic {ST_IDLE, ST_RUN} cap_state_t;

   typedef struct packed {
      logic fs;
      logic ls;
      logic le;
      logic fe;
   } cap_evt_t;

   // width codes that carry data
   localparam logic [2:0] WID_8  = 3'b000;
   localparam logic [2:0] WID_10 = 3'b001;
   localparam logic [2:0] WID_12 = 3'b010;

   function automatic logic width_ok(input logic [2:0] m);
      return (m == WID_8) || (m == WID_10) || (m == WID_12);
   endfunction

   function automatic logic width_wide(input logic [2:0] m);
      return (m == WID_10) || (m == WID_12);
   endfunction

   function automatic logic [15:0] sample_mask(input logic [2:0] m, input logic [11:0] d);
      case (m)
         WID_8:   return {8'h00, d[7:0]};
         WID_10:  return {6'h00, d[9:0]};
         default: return {4'h0, d};
      endcase
   endfunction

endpackage

// File: rtl/cam_in_sync.sv
module cam_in_sync #(
   parameter int PIX_W  = 12,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pclk_pol,
   input  logic             cam_pclk,
   input  logic             cam_vs,
   input  logic             cam_hs,
   input  logic [PIX_W-1:0] cam_data,
   output logic             strobe,
   output logic             vs_s,
   output logic             hs_s,
   output logic [PIX_W-1:0] data_s
);
   localparam int BW = PIX_W + 3;

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("cam_in_sync: STAGES must be 0..4");
   end

   logic [BW-1:0] raw, synced;
   logic          pclk_cur, pclk_prev;

   assign raw = {cam_pclk, cam_vs, cam_hs, cam_data};

   if (STAGES == 0) begin : g_direct
      assign synced = raw;
   end else begin : g_chain
      logic [BW-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign synced = stg[STAGES-1];
   end

   assign {pclk_cur, vs_s, hs_s, data_s} = synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pclk_prev <= 1'b0;
      else        pclk_prev <= pclk_cur;
   end

   assign strobe = pclk_pol ? (pclk_prev & ~pclk_cur) : (pclk_cur & ~pclk_prev);

endmodule

// File: rtl/cam_sync_fsm.sv
module cam_sync_fsm
   import cam_cap_pkg::*;
#(
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             vs_s,
   input  logic             hs_s,
   input  logic [PIX_W-1:0] data_s,
   input  logic             en,
   input  logic             frame_trig,
   input  logic             start_edge,
   input  logic             vs_pol,
   input  logic             hs_pol,
   input  logic [2:0]       mode,
   input  logic             fsm_rst,
   output cap_evt_t         evt,
   output logic             pix_vld,
   output logic [15:0]      pix,
   output logic             flush,
   output logic             halt
);
   cap_state_t state;
   logic vs_a, hs_a, vs_prev, hs_prev;
   logic start, in_frame, run;
   cap_evt_t evt_n;
   logic pix_n;

   assign vs_a = vs_s ^ vs_pol;
   assign hs_a = hs_s ^ hs_pol;
   assign run  = (state == ST_RUN);

   // an immediate stop or an honoured state-machine reset
   assign halt = !en && (!frame_trig || fsm_rst);

   assign start    = (state == ST_IDLE) && en && vs_a && (!start_edge || !vs_prev);
   assign in_frame = (run && vs_a) || start;

   always_comb begin
      evt_n.fs = strobe && start;
      evt_n.fe = strobe && run && !vs_a;
      evt_n.ls = strobe && in_frame && hs_a && !hs_prev;
      evt_n.le = strobe && run && hs_prev && !hs_a;
      pix_n    = strobe && in_frame && hs_a && width_ok(mode);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         vs_prev <= 1'b0;
         hs_prev <= 1'b0;
         evt     <= '0;
         pix_vld <= 1'b0;
         flush   <= 1'b0;
         pix     <= '0;
      end else begin
         evt     <= halt ? '0 : evt_n;
         pix_vld <= !halt && pix_n;
         flush   <= !halt && evt_n.le;
         pix     <= sample_mask(mode, data_s[11:0]);
         if (strobe) begin
            vs_prev <= vs_a;
            hs_prev <= hs_a;
         end
         if (halt)
            state <= ST_IDLE;
         else if (strobe && start)
            state <= ST_RUN;
         else if (strobe && run && !vs_a)
            state <= ST_IDLE;
      end
   end

endmodule

// File: rtl/cam_word_pack.sv
module cam_word_pack #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [15:0]       smp,
   input  logic              flush,
   input  logic              drop,
   input  logic              wide,
   input  logic              swap,
   output logic [WORD_W-1:0] word,
   output logic              word_vld
);
   localparam int N8  = WORD_W / 8;
   localparam int N16 = WORD_W / 16;
   localparam int CW  = $clog2(N8 + 1);
   localparam int SW  = $clog2(WORD_W);

   if (WORD_W % 16 != 0 || WORD_W < 16) begin : g_bad_word
      $error("cam_word_pack: WORD_W must be a nonzero multiple of 16");
   end

   logic [WORD_W-1:0] acc, acc_n, ins;
   logic [CW-1:0]     cnt, cnt_n, lanes, lane;
   logic [SW-1:0]     shamt;

   always_comb begin
      lanes = wide ? CW'(N16) : CW'(N8);
      lane  = swap ? CW'(lanes - CW'(1) - cnt) : cnt;
      shamt = wide ? (SW'(lane) << 4) : (SW'(lane) << 3);
      ins   = {{(WORD_W-16){1'b0}}, smp} << shamt;
      acc_n = acc | ins;
      cnt_n = CW'(cnt + CW'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         cnt      <= '0;
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         if (drop) begin
            acc <= '0;
            cnt <= '0;
         end else if (smp_vld) begin
            if (cnt_n == lanes) begin
               word     <= acc_n;
               word_vld <= 1'b1;
               acc      <= '0;
               cnt      <= '0;
            end else begin
               acc <= acc_n;
               cnt <= cnt_n;
            end
         end else if (flush && cnt != '0) begin
            word     <= acc;
            word_vld <= 1'b1;
            acc      <= '0;
            cnt      <= '0;
         end
      end
   end

endmodule

// File: rtl/cam_sync_capture.sv
module cam_sync_capture
   import cam_cap_pkg::*;
#(
   parameter int PIX_W       = 12,
   parameter int WORD_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cam_pclk,
   input  logic              cam_vs,
   input  logic              cam_hs,
   input  logic [PIX_W-1:0]  cam_data,
   input  logic              en,
   input  logic              frame_trig,
   input  logic              start_edge,
   input  logic              vs_pol,
   input  logic              hs_pol,
   input  logic              pclk_pol,
   input  logic [2:0]        mode,
   input  logic              swap,
   input  logic              fsm_rst,
   output logic [WORD_W-1:0] word,
   output logic              word_vld,
   output logic              frame_start,
   output logic              frame_end,
   output logic              line_start,
   output logic              line_end
);
   if (PIX_W != 12) begin : g_bad_pix
      $error("cam_sync_capture: PIX_W must be 12");
   end

   logic             strobe, vs_s, hs_s, pix_vld, flush, halt;
   logic [PIX_W-1:0] data_s;
   logic [15:0]      pix;
   cap_evt_t         evt;

   cam_in_sync #(.PIX_W(PIX_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pclk_pol(pclk_pol),
      .cam_pclk(cam_pclk), .cam_vs(cam_vs), .cam_hs(cam_hs), .cam_data(cam_data),
      .strobe(strobe), .vs_s(vs_s), .hs_s(hs_s), .data_s(data_s)
   );

   cam_sync_fsm #(.PIX_W(PIX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .strobe(strobe), .vs_s(vs_s), .hs_s(hs_s),
      .data_s(data_s), .en(en), .frame_trig(frame_trig), .start_edge(start_edge),
      .vs_pol(vs_pol), .hs_pol(hs_pol), .mode(mode), .fsm_rst(fsm_rst),
      .evt(evt), .pix_vld(pix_vld), .pix(pix), .flush(flush), .halt(halt)
   );

   cam_word_pack #(.WORD_W(WORD_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .smp_vld(pix_vld), .smp(pix), .flush(flush),
      .drop(halt), .wide(width_wide(mode)), .swap(swap),
      .word(word), .word_vld(word_vld)
   );

   assign frame_start = evt.fs;
   assign frame_end   = evt.fe;
   assign line_start  = evt.ls;
   assign line_end    = evt.le;

endmodule

// File: rtl/cam_sync_capture_chk.sv
module cam_sync_capture_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic frame_trig,
   input logic fsm_rst,
   input logic word_vld,
   input logic frame_start,
   input logic frame_end,
   input logic line_start,
   input logic line_end
);
   // R8
   fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
   // R8
   fe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end);
   // R8
   line_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_start && line_end));
   // R8
   frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_start && frame_end));
   // R9
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !frame_trig) |=> !(word_vld || frame_start || frame_end || line_start || line_end));
   // R11
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && fsm_rst) |=> !(word_vld || frame_start || frame_end || line_start || line_end));
   // R10
   start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> $past(en));
endmodule

bind cam_sync_capture cam_sync_capture_chk chk_i (
   .clk(clk), .rst_n(rst_n), .en(en), .frame_trig(frame_trig), .fsm_rst(fsm_rst),
   .word_vld(word_vld), .frame_start(frame_start), .frame_end(frame_end),
   .line_start(line_start), .line_end(line_end)
);

// File: tb/cam_sync_capture_tb_top.sv
module cam_sync_capture_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cam_pclk = 1'b0, cam_vs = 1'b0, cam_hs = 1'b0;
   logic [11:0] cam_data = '0;
   logic        en = 1'b0, frame_trig = 1'b0, start_edge = 1'b1;
   logic        vs_pol = 1'b0, hs_pol = 1'b0, pclk_pol = 1'b0, swap = 1'b0, fsm_rst = 1'b0;
   logic [2:0]  mode = 3'b000;
   logic [31:0] word;
   logic        word_vld, frame_start, frame_end, line_start, line_end;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [31:0] got_w[$], exp_w[$];
   int          got_e[$], exp_e[$];
   logic [31:0] macc;
   int          mcnt;
   bit          live;

   always #4 clk = ~clk;

   cam_sync_capture dut_i (
      .clk(clk), .rst_n(rst_n), .cam_pclk(cam_pclk), .cam_vs(cam_vs), .cam_hs(cam_hs),
      .cam_data(cam_data), .en(en), .frame_trig(frame_trig), .start_edge(start_edge),
      .vs_pol(vs_pol), .hs_pol(hs_pol), .pclk_pol(pclk_pol), .mode(mode), .swap(swap),
      .fsm_rst(fsm_rst), .word(word), .word_vld(word_vld), .frame_start(frame_start),
      .frame_end(frame_end), .line_start(line_start), .line_end(line_end)
   );

   // event codes: 1 frame start, 2 line start, 3 line end, 4 frame end
   always @(negedge clk) if (rst_n) begin
      if (frame_start) got_e.push_back(1);
      if (line_start)  got_e.push_back(2);
      if (line_end)    got_e.push_back(3);
      if (frame_end)   got_e.push_back(4);
      if (word_vld)    got_w.push_back(word);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pix(input bit va, input bit ha, input logic [11:0] d);
      @(negedge clk);
      cam_vs = va ^ vs_pol; cam_hs = ha ^ hs_pol; cam_data = d;
      repeat (4) @(negedge clk);
      cam_pclk = ~pclk_pol;
      repeat (4) @(negedge clk);
      cam_pclk = pclk_pol;
   endtask

   // bench model of the packing rules (R4, R6, R7)
   task automatic model_pix(input logic [11:0] d);
      int lw, lanes, lane;
      logic [31:0] v;
      if (mode > 3'd2) return;
      lw    = (mode == 3'd0) ? 8 : 16;
      lanes = 32 / lw;
      v = (mode == 3'd0) ? {24'h0, d[7:0]} : (mode == 3'd1) ? {22'h0, d[9:0]} : {20'h0, d};
      lane = swap ? (lanes - 1 - mcnt) : mcnt;
      macc = macc | (v << (lane * lw));
      mcnt++;
      if (mcnt == lanes) begin exp_w.push_back(macc); macc = '0; mcnt = 0; end
   endtask

   task automatic model_flush();
      if (mcnt != 0) exp_w.push_back(macc);
      macc = '0; mcnt = 0;
   endtask

   task automatic do_cut(input int act);
      repeat (4) @(negedge clk);
      case (act)
         1: begin en = 0; live = 0; macc = '0; mcnt = 0; end
         2: en = 0;
         3: begin en = 0; @(negedge clk) fsm_rst = 1; @(negedge clk) fsm_rst = 0;
                  live = 0; macc = '0; mcnt = 0; end
         4: begin @(negedge clk) fsm_rst = 1; @(negedge clk) fsm_rst = 0; end
         default: ;
      endcase
   endtask

   task automatic compare(input string tag);
      repeat (16) @(negedge clk);
      chk(got_w.size() == exp_w.size(), {tag, " word count"}, got_w.size(), exp_w.size());
      for (int i = 0; i < got_w.size() && i < exp_w.size(); i++)
         chk(got_w[i] === exp_w[i], {tag, " word"}, got_w[i], exp_w[i]);
      chk(got_e.size() == exp_e.size(), {tag, " event count"}, got_e.size(), exp_e.size());
      for (int i = 0; i < got_e.size() && i < exp_e.size(); i++)
         chk(got_e[i] == exp_e[i], {tag, " event order"}, got_e[i], exp_e[i]);
      got_w.delete(); exp_w.delete(); got_e.delete(); exp_e.delete();
   endtask

   task automatic run_frame(input int nl, input int np, input int seed, input bit mid,
                            input int cut_l, input int cut_p, input int act, input string tag);
      bit fs_pend;
      macc = '0; mcnt = 0;
      pix(0, 0, 0); pix(0, 0, 0);
      if (mid) begin
         en = 0;
         pix(1, 0, 0); pix(1, 0, 0);
         en = 1;
         live = !start_edge;
         fs_pend = 1;
      end else begin
         live = en;
         pix(1, 0, 0);
         if (live) exp_e.push_back(1);
         fs_pend = 0;
      end
      for (int l = 0; l < nl; l++) begin
         for (int p = 0; p < np; p++) begin
            logic [11:0] d;
            d = 12'((seed * 29 + l * 17 + p * 7 + 5) * 97);
            if (live && fs_pend && p == 0) begin exp_e.push_back(1); fs_pend = 0; end
            if (live && p == 0) exp_e.push_back(2);
            pix(1, 1, d);
            if (live) model_pix(d);
            if (l == cut_l && p == cut_p) do_cut(act);
         end
         pix(1, 0, 0);
         if (live) begin model_flush(); exp_e.push_back(3); end
      end
      pix(0, 0, 0);
      if (live) exp_e.push_back(4);
      pix(0, 0, 0);
      compare(tag);
   endtask

   initial begin : wd
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk({word_vld, frame_start, frame_end, line_start, line_end} == 5'b0, "R12 outputs in reset",
          {word_vld, frame_start, frame_end, line_start, line_end}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk({word_vld, frame_start, frame_end, line_start, line_end} == 5'b0 && word == 0,
          "R12 outputs after reset", word, 0);

      // sweep: width code, swap, clock edge, sync polarities (R1 R2 R4 R5 R6 R7 R8)
      en = 1; frame_trig = 0; start_edge = 1;
      for (int c = 0; c < 128; c++) begin
         @(negedge clk);
         mode = 3'(c); swap = c[3]; pclk_pol = c[4]; vs_pol = c[5]; hs_pol = c[6];
         cam_pclk = pclk_pol; cam_vs = vs_pol; cam_hs = hs_pol;
         repeat (8) @(negedge clk);
         run_frame(2, 5, c, 0, -1, -1, 0,
                   (mode <= 3'd2) ? "R1 R2 R4 R6 R7 R8 sweep" : "R5 R8 reserved width");
      end

      @(negedge clk);
      mode = 3'd0; swap = 0; pclk_pol = 0; vs_pol = 0; hs_pol = 0;
      cam_pclk = 0; cam_vs = 0; cam_hs = 0;
      repeat (8) @(negedge clk);

      // R3: level start picks up a frame already in progress
      start_edge = 0;
      run_frame(1, 4, 200, 1, -1, -1, 0, "R3 level start mid-frame");
      // R3: edge start ignores it, then takes the next full frame
      start_edge = 1;
      run_frame(1, 4, 201, 1, -1, -1, 0, "R3 edge start mid-frame");
      run_frame(1, 4, 202, 0, -1, -1, 0, "R3 edge start next frame");

      // R9: immediate stop mid-line drops partial word
      en = 1; frame_trig = 0;
      run_frame(2, 6, 210, 0, 0, 2, 1, "R9 immediate stop");
      run_frame(1, 4, 211, 0, -1, -1, 0, "R9 stays stopped");

      // R10: deferred stop completes the frame, then no new frame
      en = 1; frame_trig = 1;
      run_frame(2, 6, 220, 0, 0, 2, 2, "R10 deferred stop");
      run_frame(1, 4, 221, 0, -1, -1, 0, "R10 no frame after stop");

      // R11: state-machine reset honoured while disabled
      en = 1; frame_trig = 1;
      run_frame(2, 6, 230, 0, 1, 1, 3, "R11 reset while disabled");
      // R11: ignored while enabled
      en = 1; frame_trig = 0;
      run_frame(2, 6, 240, 0, 0, 3, 4, "R11 reset ignored when enabled");

      // R9 with swap and wide samples
      mode = 3'd2; swap = 1; en = 1;
      run_frame(2, 3, 250, 0, 1, 0, 1, "R9 R6 immediate stop wide");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule